// File: doc/BRIEF.md
# Programmable Countdown Timer with Binary Prescaler

This block counts down from a value written by software. A bus-clock tick strobe drives an internal prescaler. The prescaler divides the tick rate by a power of two chosen through a 4-bit configuration code. Each time the prescaler wraps, the current count drops by one. When the count expires, the block increments a saturating pending-expiry counter.

In one-shot mode the count stops at zero. In periodic mode it reloads the initial value and continues. The interrupt side sees a request while expiries are pending and the vector entry is unmasked. Each delivery it performs is acknowledged with a one-cycle pulse, and that pulse removes one pending expiry. Masking hides the request but does not stop the countdown or the accumulation of expiries.

Top module: `cdt_timer`

## Requirements
- R1: The prescale ratio is 2^t, where t = ({code[3], code[1:0]} + 1) mod 8. Code 0000 gives 2, 0001 gives 4, 1010 gives 128 and 1011 gives 1. Code bit 2 has no effect.
- R2: While running, the current count decreases by one on the tick that completes each group of ratio ticks. Cycles with tick_i low do not advance the prescaler.
- R3: A write of the initial count loads it into the current count in the same clock edge, restarts the prescaler from zero and abandons any countdown in progress.
- R4: A written initial count of zero leaves the timer stopped, with cur_count_o reading zero.
- R5: With periodic_i low, the count stays at zero after it expires until the next initial-count write.
- R6: With periodic_i high, an expiry reloads the initial count in the same edge, and counting continues.
- R7: Each expiry adds one to pending_o. pending_o saturates at its all-ones value.
- R8: An initial-count write sets pending_o to zero.
- R9: An ack_i pulse removes one pending expiry only when the entry is unmasked and pending_o is nonzero. Otherwise it is ignored.
- R10: irq_req_o is high exactly when pending_o is nonzero and the entry is unmasked. Masking does not stop counting or expiry accumulation.
- R11: A new prescale code takes effect at the next prescaler wrap, or at the next restart if that comes first. Writing the code does not change the current count.
- R12: After reset the timer is stopped, the count, pending_o and the prescale code are zero, and the entry is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bus-clock tick strobe |
| init_we_i | input | 1 | Initial-count write strobe |
| init_val_i | input | CNT_W | Initial count value |
| div_we_i | input | 1 | Prescale code write strobe |
| div_cfg_i | input | 4 | Prescale code |
| periodic_i | input | 1 | 1 = periodic, 0 = one-shot |
| mask_we_i | input | 1 | Mask write strobe |
| mask_val_i | input | 1 | Mask value (1 = masked) |
| ack_i | input | 1 | Delivery acknowledge pulse |
| cur_count_o | output | CNT_W | Current count |
| pending_o | output | PEND_W | Pending expiry count |
| irq_req_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 16-bit count and a 3-bit pending counter. With a 3-bit pending counter, saturation at seven is reached in about a dozen cycles of a periodic count of one. The narrow count keeps every scenario short, and the largest ratio of 128 is still reached within a few hundred cycles. The default widths change only the data path lengths, so the same prescaler and sequencing logic is exercised.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned SHIFT_W = 3;
  localparam int unsigned PRE_W   = (1 << SHIFT_W) - 1;

  // {b3,b1,b0} + 1, wrapping in 3 bits
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [SHIFT_W-1:0] packed_code);
    return packed_code + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               step_o
);
  logic [SHIFT_W-1:0] act_shift_q;
  logic [PRE_W-1:0]   pre_q;
  logic [PRE_W-1:0]   lim;
  logic               wrap;

  assign lim    = PRE_W'((8'd1 << act_shift_q) - 8'd1);
  assign wrap   = run_i && tick_i && (pre_q == lim);
  assign step_o = wrap && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q       <= '0;
      act_shift_q <= '0;
    end else if (restart_i) begin
      pre_q       <= '0;
      act_shift_q <= shift_i;
    end else if (run_i && tick_i) begin
      if (wrap) begin
        pre_q       <= '0;
        act_shift_q <= shift_i;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] init_q, cur_q;
  logic             run_q;

  assign expire_o = step_i && (cur_q == CNT_W'(1));
  assign cur_o    = cur_q;
  assign run_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      cur_q  <= '0;
      run_q  <= 1'b0;
    end else if (load_i) begin
      init_q <= load_val_i;
      cur_q  <= load_val_i;
      run_q  <= (load_val_i != '0);
    end else if (step_i) begin
      if (expire_o) begin
        cur_q <= periodic_i ? init_q : '0;
        run_q <= periodic_i;
      end else begin
        cur_q <= cur_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cdt_pending.sv
module cdt_pending #(
  parameter int unsigned PEND_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              inc_i,
  input  logic              dec_req_i,
  input  logic              allow_i,
  output logic [PEND_W-1:0] cnt_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] cnt_q;
  logic              dec;

  assign dec   = dec_req_i && allow_i && (cnt_q != '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec})
        2'b10:   if (cnt_q != PEND_MAX) cnt_q <= cnt_q + PEND_W'(1);
        2'b01:   cnt_q <= cnt_q - PEND_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PEND_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              init_we_i,
  input  logic [CNT_W-1:0]  init_val_i,
  input  logic              div_we_i,
  input  logic [3:0]        div_cfg_i,
  input  logic              periodic_i,
  input  logic              mask_we_i,
  input  logic              mask_val_i,
  input  logic              ack_i,
  output logic [CNT_W-1:0]  cur_count_o,
  output logic [PEND_W-1:0] pending_o,
  output logic              irq_req_o
);
  logic [SHIFT_W-1:0] code_q, code_next;
  logic               mask_q;
  logic               run, step, expire;
  logic               cfg_unused;

  // code bit 2 plays no part in the ratio
  assign cfg_unused = div_cfg_i[2];
  assign code_next  = div_we_i ? {div_cfg_i[3], div_cfg_i[1:0]} : code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= 1'b1;
    end else begin
      if (div_we_i)  code_q <= {div_cfg_i[3], div_cfg_i[1:0]};
      if (mask_we_i) mask_q <= mask_val_i;
    end
  end

  cdt_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (init_we_i),
    .run_i     (run),
    .tick_i    (tick_i),
    .shift_i   (code_to_shift(code_next)),
    .step_o    (step)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (init_we_i),
    .load_val_i (init_val_i),
    .step_i     (step),
    .periodic_i (periodic_i),
    .cur_o      (cur_count_o),
    .run_o      (run),
    .expire_o   (expire)
  );

  cdt_pending #(.PEND_W(PEND_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (init_we_i),
    .inc_i     (expire),
    .dec_req_i (ack_i),
    .allow_i   (!mask_q),
    .cnt_o     (pending_o)
  );

  assign irq_req_o = (pending_o != '0) && !mask_q;
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PEND_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_we_i,
  input logic              mask_i,
  input logic [CNT_W-1:0]  cur_count_o,
  input logic [PEND_W-1:0] pending_o,
  input logic              irq_req_o
);
  assert_pend_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_we_i |=> (pending_o == '0));

  assert_zero_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_count_o == '0 && !init_we_i) |=> (cur_count_o == '0));

  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_we_i && cur_count_o > CNT_W'(1)) |=>
      (cur_count_o == $past(cur_count_o) || cur_count_o + CNT_W'(1) == $past(cur_count_o)));

  assert_masked_no_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && !init_we_i) |=> (pending_o >= $past(pending_o)));

  assert_req_needs_pend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (pending_o != '0 && !mask_i));
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_we_i   (init_we_i),
  .mask_i      (mask_q),
  .cur_count_o (cur_count_o),
  .pending_o   (pending_o),
  .irq_req_o   (irq_req_o)
);

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned PEND_W = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b1;
  logic              init_we_i = 1'b0;
  logic [CNT_W-1:0]  init_val_i = '0;
  logic              div_we_i = 1'b0;
  logic [3:0]        div_cfg_i = '0;
  logic              periodic_i = 1'b0;
  logic              mask_we_i = 1'b0;
  logic              mask_val_i = 1'b0;
  logic              ack_i = 1'b0;
  logic [CNT_W-1:0]  cur_count_o;
  logic [PEND_W-1:0] pending_o;
  logic              irq_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  cdt_timer #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_cdt_timer (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_init(input int v);
    init_we_i = 1'b1; init_val_i = CNT_W'(v);
    @(negedge clk_i);
    init_we_i = 1'b0;
  endtask

  task automatic wr_div(input logic [3:0] c);
    div_we_i = 1'b1; div_cfg_i = c;
    @(negedge clk_i);
    div_we_i = 1'b0;
  endtask

  task automatic wr_mask(input logic m);
    mask_we_i = 1'b1; mask_val_i = m;
    @(negedge clk_i);
    mask_we_i = 1'b0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R12 count", int'(cur_count_o), 0);
    chk("R12 pending", int'(pending_o), 0);
    chk("R12 irq", int'(irq_req_o), 0);
    wr_div(4'b0000);
    wr_init(3);
    wait_n(6);
    chk("R12 masked after reset pending", int'(pending_o), 1);
    chk("R12 masked after reset irq", int'(irq_req_o), 0);
    chk("R5 oneshot at zero", int'(cur_count_o), 0);
    wait_n(4);
    chk("R5 oneshot sticks", int'(cur_count_o), 0);
    wr_mask(1'b0);
    chk("R10 unmasked irq", int'(irq_req_o), 1);
  endtask

  task automatic t_zero_init();
    wr_init(0);
    chk("R8 pending cleared", int'(pending_o), 0);
    chk("R4 zero count", int'(cur_count_o), 0);
    wait_n(10);
    chk("R4 stays stopped", int'(cur_count_o), 0);
  endtask

  task automatic t_ratio(input logic [3:0] c, input int r, input string tag);
    wr_div(c);
    wr_init(200);
    wait_n(3 * r - 1);
    chk({"R1 ratio before wrap ", tag}, int'(cur_count_o), 198);
    wait_n(1);
    chk({"R1 ratio at wrap ", tag}, int'(cur_count_o), 197);
  endtask

  task automatic t_sparse();
    wr_div(4'b1011);
    wr_init(50);
    for (int i = 0; i < 10; i++) begin
      tick_i = (i % 2 == 1);
      @(negedge clk_i);
    end
    tick_i = 1'b1;
    chk("R2 sparse ticks", int'(cur_count_o), 45);
  endtask

  task automatic t_restart();
    wr_div(4'b0001);
    wr_init(100);
    wait_n(6);
    chk("R2 ratio4 step", int'(cur_count_o), 99);
    wr_init(50);
    chk("R3 reload", int'(cur_count_o), 50);
    wait_n(3);
    chk("R3 prescaler restarted", int'(cur_count_o), 50);
    wait_n(1);
    chk("R3 first step after restart", int'(cur_count_o), 49);
  endtask

  task automatic t_div_change();
    wr_div(4'b0000);
    wr_init(10);
    wr_div(4'b1011);
    chk("R11 count kept", int'(cur_count_o), 10);
    wait_n(1);
    chk("R11 old ratio until wrap", int'(cur_count_o), 9);
    wait_n(2);
    chk("R11 new ratio after wrap", int'(cur_count_o), 7);
  endtask

  task automatic t_periodic();
    periodic_i = 1'b1;
    wr_div(4'b1011);
    wr_init(5);
    wait_n(5);
    chk("R6 reload value", int'(cur_count_o), 5);
    chk("R7 first expiry", int'(pending_o), 1);
    wait_n(2);
    chk("R6 continues", int'(cur_count_o), 3);
    wait_n(3);
    chk("R7 second expiry", int'(pending_o), 2);
    wr_init(1);
    chk("R8 cleared on write", int'(pending_o), 0);
    wait_n(12);
    chk("R7 saturation", int'(pending_o), 7);
    periodic_i = 1'b0;
    wr_init(0);
  endtask

  task automatic t_ack_mask();
    wr_div(4'b1011);
    wr_init(3);
    wait_n(3);
    chk("R9 pend before ack", int'(pending_o), 1);
    chk("R10 irq raised", int'(irq_req_o), 1);
    wr_mask(1'b1);
    chk("R10 mask hides irq", int'(irq_req_o), 0);
    do_ack();
    chk("R9 masked ack ignored", int'(pending_o), 1);
    wr_mask(1'b0);
    chk("R10 irq back", int'(irq_req_o), 1);
    do_ack();
    chk("R9 ack decrements", int'(pending_o), 0);
    chk("R10 irq drops", int'(irq_req_o), 0);
    do_ack();
    chk("R9 ack at zero ignored", int'(pending_o), 0);
    wr_mask(1'b1);
    wr_init(10);
    wait_n(4);
    chk("R10 counts while masked", int'(cur_count_o), 6);
    wait_n(6);
    chk("R10 expiry while masked", int'(pending_o), 1);
    chk("R10 no irq while masked", int'(irq_req_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_zero_init();
    t_ratio(4'b1011, 1, "1011");
    t_ratio(4'b0000, 2, "0000");
    t_ratio(4'b0001, 4, "0001");
    t_ratio(4'b0100, 2, "0100 bit2 ignored");
    t_ratio(4'b1010, 128, "1010");
    t_sparse();
    t_restart();
    t_div_change();
    t_periodic();
    t_ack_mask();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule